// File: doc/BRIEF.md
# Host-Bound Packet Streaming Source

This block sits on the FPGA side of a 16-bit bridge bus and feeds sample data toward a host in fixed packets. On its write side it accepts complex samples (a 16-bit I value and a 16-bit Q value together) and turns each one into two consecutive FIFO write words, I first and Q second. If a sample cannot be taken, the block drops it and raises a sticky overrun flag.

On its read side it watches the fill level of an external receive FIFO. It raises a ready flag whenever at least one whole packet of 512 bytes (256 words, or 128 complex samples) is stored. The bridge master polls this flag and then holds its active-high read-enable and output-enable strobes for a transfer. While read-enable is high, the block pops one word per clock from the FIFO and keeps count. It stops popping after exactly one packet, even if the master holds the strobe for extra cycles. The FIFO storage and any clock crossing are outside the block: level, head data and full are inputs, and the read and write requests are outputs. The FIFO is assumed to show its head word on `fifo_rdata` before the pop.

Top module: `rx_pkt_source`

## Requirements
- R1: After reset, `pkt_ready`, `fifo_rd`, `fifo_wr` and `overrun` are 0, and `bus_data` is 0.
- R2: `pkt_ready` is a registered flag. It is 1 in the cycle after a cycle in which `fifo_level` is at least 256, and 0 in the cycle after a cycle in which `fifo_level` is 255 or less.
- R3: `fifo_rd` is high, combinationally, in every cycle where `m_re` is high and fewer than 256 words have been popped since `m_re` rose. Once 256 words have been popped, it stays low for as long as `m_re` stays high.
- R4: A cycle with `m_re` low clears the word count. The next `m_re` high period pops again from the first word, including when the previous period ended part-way through a packet.
- R5: When `m_oe` is low, `bus_data` is 0. When `m_oe` is high and the packet is still in progress, `bus_data` equals `fifo_rdata` in the same cycle.
- R6: When `m_oe` is high but 256 words have already been popped in the current `m_re` period, `bus_data` is 0.
- R7: A sample taken on `smp_valid` produces `fifo_wr`=1 with `fifo_wdata`=I in the next cycle, and `fifo_wr`=1 with `fifo_wdata`=Q in the cycle after that. A new sample may be taken in the same cycle as that Q word.
- R8: A sample presented while `fifo_full` is high is dropped: no `fifo_wr` follows from it. `overrun` is 1 from the next cycle on.
- R9: A sample presented in the cycle right after an accepted sample, while that sample's I word is still pending, is dropped and sets `overrun`. The earlier sample's Q word is still written.
- R10: `overrun` stays set until a cycle with `ovr_clr` high, which clears it on the next cycle. If a new overrun happens in the same cycle as `ovr_clr`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_level | input | 12 | Words currently held in the receive FIFO |
| fifo_rdata | input | 16 | Head word of the receive FIFO (show-ahead) |
| fifo_full | input | 1 | Receive FIFO cannot accept a sample |
| smp_valid | input | 1 | A complex sample is offered this cycle |
| smp_i | input | 16 | In-phase part of the offered sample |
| smp_q | input | 16 | Quadrature part of the offered sample |
| ovr_clr | input | 1 | Clears the overrun flag |
| m_oe | input | 1 | Master output-enable strobe, active high |
| m_re | input | 1 | Master read-enable strobe, active high |
| pkt_ready | output | 1 | At least one whole packet is waiting |
| fifo_rd | output | 1 | Pop request to the receive FIFO |
| bus_data | output | 16 | Word driven toward the bridge |
| fifo_wr | output | 1 | Write request to the receive FIFO |
| fifo_wdata | output | 16 | Word to write (I, then Q) |
| overrun | output | 1 | Sticky flag: a sample was dropped |

## Verification
If the word counter is wrong, the error shows at the ports within one packet. It appears as a pop beyond word 256, a missing pop before it, or a restarted burst that pops too few words. In each case the fault is visible in the very cycle `fifo_rd` or `bus_data` disagrees. If the packer phase is wrong, the I and Q words are swapped, duplicated or missing, and this is seen on `fifo_wr` and `fifo_wdata` one or two cycles after the sample. A faulty overrun flag shows on the cycle after a rejected sample or a clear pulse.

// File: rtl/rx_pkt_source.sv
module rx_pkt_source #(
  parameter int DW        = 16,
  parameter int PKT_BYTES = 512,
  parameter int LVL_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [DW-1:0]    fifo_rdata,
  input  logic             fifo_full,
  input  logic             smp_valid,
  input  logic [DW-1:0]    smp_i,
  input  logic [DW-1:0]    smp_q,
  input  logic             ovr_clr,
  input  logic             m_oe,
  input  logic             m_re,
  output logic             pkt_ready,
  output logic             fifo_rd,
  output logic [DW-1:0]    bus_data,
  output logic             fifo_wr,
  output logic [DW-1:0]    fifo_wdata,
  output logic             overrun
);
  localparam int PKT_WORDS = PKT_BYTES / (DW / 8);
  localparam int CW        = $clog2(PKT_WORDS + 1);

  logic [CW-1:0] wcnt;
  logic          in_pkt;
  logic          ph_i, ph_q;
  logic [DW-1:0] i_hold, q_hold;
  logic          take, reject;

  assign in_pkt   = wcnt < CW'(PKT_WORDS);
  assign fifo_rd  = m_re && in_pkt;
  assign bus_data = (m_oe && in_pkt) ? fifo_rdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       wcnt <= '0;
    else if (!m_re)   wcnt <= '0;
    else if (fifo_rd) wcnt <= wcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pkt_ready <= 1'b0;
    else        pkt_ready <= fifo_level >= LVL_W'(PKT_WORDS);

  assign reject = smp_valid && (fifo_full || ph_i);
  assign take   = smp_valid && !reject;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph_i   <= 1'b0;
      ph_q   <= 1'b0;
      i_hold <= '0;
      q_hold <= '0;
    end else begin
      ph_i <= take;
      ph_q <= ph_i;
      if (take) begin
        i_hold <= smp_i;
        q_hold <= smp_q;
      end
    end

  assign fifo_wr    = ph_i || ph_q;
  assign fifo_wdata = ph_i ? i_hold : q_hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       overrun <= 1'b0;
    else if (reject)  overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
endmodule

// File: rtl/rx_pkt_source_chk.sv
module rx_pkt_source_chk #(
  parameter int DW        = 16,
  parameter int PKT_BYTES = 512,
  parameter int LVL_W     = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_full,
  input logic             smp_valid,
  input logic             ovr_clr,
  input logic             m_oe,
  input logic             m_re,
  input logic             pkt_ready,
  input logic             fifo_rd,
  input logic [DW-1:0]    bus_data,
  input logic             overrun
);
  localparam int PKT_WORDS = PKT_BYTES / (DW / 8);

  int pops;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pops <= 0;
    else if (!m_re)   pops <= 0;
    else if (fifo_rd) pops <= pops + 1;

  // R2
  ready_follows_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level >= LVL_W'(PKT_WORDS)) |=> pkt_ready);

  // R3
  pop_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> m_re);

  // R3
  pop_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (pops < PKT_WORDS));

  // R5
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_oe |-> (bus_data == '0));

  // R8
  full_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fifo_full) |=> overrun);

  // R10
  sticky_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);
endmodule

bind rx_pkt_source rx_pkt_source_chk #(.DW(DW), .PKT_BYTES(PKT_BYTES), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .fifo_full(fifo_full),
  .smp_valid(smp_valid), .ovr_clr(ovr_clr), .m_oe(m_oe), .m_re(m_re),
  .pkt_ready(pkt_ready), .fifo_rd(fifo_rd), .bus_data(bus_data), .overrun(overrun)
);

// File: tb/rx_pkt_source_test.sv
module rx_pkt_source_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] fifo_level = '0;
  logic [15:0] fifo_rdata = '0;
  logic        fifo_full = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_i = '0, smp_q = '0;
  logic        ovr_clr = 1'b0, m_oe = 1'b0, m_re = 1'b0;
  logic        pkt_ready, fifo_rd, fifo_wr, overrun;
  logic [15:0] bus_data, fifo_wdata;

  int vectors = 0, errors = 0;
  bit done = 0;

  rx_pkt_source uut (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .fifo_rdata(fifo_rdata),
    .fifo_full(fifo_full), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .ovr_clr(ovr_clr), .m_oe(m_oe), .m_re(m_re), .pkt_ready(pkt_ready),
    .fifo_rd(fifo_rd), .bus_data(bus_data), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .overrun(overrun)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 pkt_ready", pkt_ready, 0);
    chk("R1 fifo_rd", fifo_rd, 0);
    chk("R1 fifo_wr", fifo_wr, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 bus_data", bus_data, 0);
  endtask

  task automatic t_ready();
    fifo_level = 12'd255; step();
    chk("R2 level 255", pkt_ready, 0);
    fifo_level = 12'd256; step();
    chk("R2 level 256", pkt_ready, 1);
    fifo_level = 12'd4095; step();
    chk("R2 level max", pkt_ready, 1);
    fifo_level = 12'd0; step();
    chk("R2 level 0", pkt_ready, 0);
  endtask

  task automatic t_burst();
    m_re = 1; m_oe = 1;
    for (int k = 0; k < 259; k++) begin
      fifo_rdata = 16'hA000 + 16'(k);
      #1;
      chk("R3 pop", fifo_rd, (k < 256) ? 1 : 0);
      if (k < 256) chk("R5 bus data", bus_data, 16'hA000 + 16'(k));
      else         chk("R6 bus past packet", bus_data, 0);
      @(negedge clk);
    end
    m_re = 0; m_oe = 0; #1;
    chk("R3 strobe low", fifo_rd, 0);
    chk("R5 oe low", bus_data, 0);
    step();
    m_re = 1; m_oe = 1; #1;
    chk("R4 restart pop", fifo_rd, 1);
    step();
    chk("R4 restart pop 2", fifo_rd, 1);
    m_re = 0; m_oe = 0; step();
  endtask

  task automatic t_partial();
    int n = 0;
    m_re = 1;
    for (int k = 0; k < 10; k++) step();
    m_re = 0; step();
    m_re = 1;
    for (int k = 0; k < 260; k++) begin
      #1;
      if (fifo_rd) n++;
      @(negedge clk);
    end
    chk("R4 full packet after partial", n, 256);
    m_re = 0; step();
  endtask

  task automatic t_oe_low();
    m_re = 1; m_oe = 0; fifo_rdata = 16'h5A5A; #1;
    chk("R5 pop without oe", fifo_rd, 1);
    chk("R5 bus zero without oe", bus_data, 0);
    m_re = 0; step();
  endtask

  task automatic t_pack();
    smp_valid = 1; smp_i = 16'h1111; smp_q = 16'h2222; #1;
    chk("R7 no write yet", fifo_wr, 0);
    @(negedge clk); smp_valid = 0; #1;
    chk("R7 I write", fifo_wr, 1);
    chk("R7 I data", fifo_wdata, 16'h1111);
    @(negedge clk); smp_valid = 1; smp_i = 16'h3333; smp_q = 16'h4444; #1;
    chk("R7 Q write", fifo_wr, 1);
    chk("R7 Q data", fifo_wdata, 16'h2222);
    @(negedge clk); smp_valid = 0; #1;
    chk("R7 back-to-back I", fifo_wdata, 16'h3333);
    step();
    chk("R7 back-to-back Q", fifo_wdata, 16'h4444);
    chk("R7 no overrun", overrun, 0);
    step();
    chk("R7 idle", fifo_wr, 0);
  endtask

  task automatic t_full();
    fifo_full = 1; smp_valid = 1; smp_i = 16'h7777;
    @(negedge clk); fifo_full = 0; smp_valid = 0; #1;
    chk("R8 dropped", fifo_wr, 0);
    chk("R8 overrun set", overrun, 1);
    step(); step();
    chk("R10 overrun held", overrun, 1);
    ovr_clr = 1;
    @(negedge clk); ovr_clr = 0; #1;
    chk("R10 cleared", overrun, 0);
  endtask

  task automatic t_spacing();
    smp_valid = 1; smp_i = 16'h8888; smp_q = 16'h9999;
    @(negedge clk); smp_i = 16'hBBBB; smp_q = 16'hCCCC; #1;
    chk("R9 first I", fifo_wdata, 16'h8888);
    @(negedge clk); smp_valid = 0; #1;
    chk("R9 overrun", overrun, 1);
    chk("R9 first Q kept", fifo_wdata, 16'h9999);
    step();
    chk("R9 second dropped", fifo_wr, 0);
    fifo_full = 1; smp_valid = 1; ovr_clr = 1;
    @(negedge clk); fifo_full = 0; smp_valid = 0; ovr_clr = 0; #1;
    chk("R10 set wins over clear", overrun, 1);
    ovr_clr = 1;
    @(negedge clk); ovr_clr = 0; #1;
    chk("R10 final clear", overrun, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 3);
    @(negedge clk); rst_n = 1; #1;
    t_reset();
    t_ready();
    @(negedge clk);
    t_burst();
    t_partial();
    t_oe_low();
    t_pack();
    t_full();
    t_spacing();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule